// File: doc/BRIEF.md
# Partial-Width Architectural Register File

This block stores a set of 64-bit architectural registers that can be written and read through narrower views. Five views share the same storage: the full 64 bits, the low 32 bits, the low 16 bits, the low byte, and the second byte (bits 15:8). Each cycle one write port can update one register. Two combinational read ports each return one view of one register.

The write rules are deliberately asymmetric. A 32-bit write zero-extends into the upper half, so the result never depends on the old contents. The 16-bit, low-byte and second-byte writes merge their data into the old value and leave every bit outside their field untouched. The second-byte view exists only for the first few registers. A second-byte write aimed at any other register is dropped and raises an error pulse. A read of the register being written in the same cycle returns the merged post-write value.

All views use a 3-bit code with the same encoding on the write port and on the read ports:

| Code | View |
|------|------|
| 000 | full 64 bits |
| 001 | low 32 bits |
| 010 | low 16 bits |
| 011 | low byte |
| 100 | second byte (bits 15:8) |

Codes 101, 110 and 111 are unused.

Top module: `prf_regfile`

## Requirements
- R1: A synchronous active-high reset on `rst_i` clears all 16 registers to zero and clears `wr_err_o`.
- R2: A write with code 000 replaces all 64 bits of register `wr_idx_i` with `wr_data_i`.
- R3: A write with code 001 stores `wr_data_i[31:0]` in bits 31:0 and forces bits 63:32 to zero. This also holds when the data is zero.
- R4: A write with code 010 replaces bits 15:0 with `wr_data_i[15:0]` and keeps bits 63:16.
- R5: A write with code 011 replaces bits 7:0 with `wr_data_i[7:0]` and keeps bits 63:8.
- R6: A write with code 100 to register index 0 to 3 places `wr_data_i[7:0]` in bits 15:8 and keeps bits 63:16 and 7:0.
- R7: A write with code 100 to register index 4 to 15 leaves every register unchanged. It sets `wr_err_o` high in the following cycle only, and `wr_err_o` is low after every other cycle.
- R8: A write with code 101, 110 or 111 changes no register and raises no error.
- R9: Each read port returns its selected view shifted down to bit 0 and zero-extended to 64 bits. A read returns zero for codes 101 to 111, and for code 100 on index 4 to 15.
- R10: When a read port addresses the register that a committing write targets in the same cycle, it returns the post-write value. A write that does not commit (R7, R8) is not forwarded.
- R11: A write changes only the register selected by `wr_idx_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write request this cycle |
| wr_idx_i | input | 4 | Register index of the write |
| wr_sel_i | input | 3 | View code of the write |
| wr_data_i | input | 64 | Write data, right-aligned to the view |
| rd_idx_i | input | 2 x 4 | Register index of each read port |
| rd_sel_i | input | 2 x 3 | View code of each read port |
| rd_data_o | output | 2 x 64 | Selected view of each read port, zero-extended |
| wr_err_o | output | 1 | One-cycle pulse after a dropped second-byte write |

## Verification
The bench writes all-ones patterns with 32-bit views and zero data. A design that merged instead of zero-extending would keep stale upper bits and fail R3. The bench also writes second-byte data into registers whose low byte and upper bytes are nonzero, which exposes a field that is shifted by one byte or that clobbers a neighbour.

It issues second-byte writes to register 4 and above and checks the following cycle. A design that still stored the data, forwarded it, or held the error flag longer than one cycle would show it on the next read or on `wr_err_o`.

Random traffic with indices biased toward a few registers makes same-cycle read/write collisions common. This catches a read port that returns the stale value or that forwards a write that was dropped.

// File: rtl/prf_pkg.sv
package prf_pkg;

    localparam int SELW = 3;

    // View / write-width code shared by the write port and the read ports
    typedef enum logic [SELW-1:0] {
        VW_FULL = 3'd0,
        VW_LO32 = 3'd1,
        VW_LO16 = 3'd2,
        VW_LO8  = 3'd3,
        VW_B1   = 3'd4
    } view_e;

endpackage

// File: rtl/prf_wmerge.sv
module prf_wmerge
    import prf_pkg::*;
#(
    parameter int DW  = 64,
    parameter int IW  = 4,
    parameter int NHB = 4
) (
    input  logic            en_i,
    input  logic [IW-1:0]   idx_i,
    input  logic [SELW-1:0] sel_i,
    input  logic [DW-1:0]   data_i,
    input  logic [DW-1:0]   old_i,
    output logic [DW-1:0]   new_o,
    output logic            commit_o,
    output logic            bad_o
);

    localparam int HALF = DW / 2;
    localparam logic [IW:0] NHB_W = (IW+1)'(NHB);

    logic hb_ok;
    logic view_ok;

    assign hb_ok = ({1'b0, idx_i} < NHB_W);

    always_comb begin
        new_o   = old_i;
        view_ok = 1'b0;
        unique case (sel_i)
            VW_FULL: begin
                new_o   = data_i;
                view_ok = 1'b1;
            end
            VW_LO32: begin
                new_o   = {{HALF{1'b0}}, data_i[HALF-1:0]};
                view_ok = 1'b1;
            end
            VW_LO16: begin
                new_o   = {old_i[DW-1:16], data_i[15:0]};
                view_ok = 1'b1;
            end
            VW_LO8: begin
                new_o   = {old_i[DW-1:8], data_i[7:0]};
                view_ok = 1'b1;
            end
            VW_B1: begin
                new_o   = {old_i[DW-1:16], data_i[7:0], old_i[7:0]};
                view_ok = hb_ok;
            end
            default: begin
                new_o   = old_i;
                view_ok = 1'b0;
            end
        endcase
    end

    assign commit_o = en_i & view_ok;
    assign bad_o    = en_i & (sel_i == VW_B1) & ~hb_ok;

endmodule

// File: rtl/prf_store.sv
module prf_store #(
    parameter int DW   = 64,
    parameter int NREG = 16,
    parameter int IW   = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      we_i,
    input  logic [IW-1:0]             widx_i,
    input  logic [DW-1:0]             wval_i,
    output logic [NREG-1:0][DW-1:0]   regs_o
);

    logic [NREG-1:0][DW-1:0] regs_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q <= '0;
        end else if (we_i) begin
            regs_q[widx_i] <= wval_i;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/prf_rview.sv
module prf_rview
    import prf_pkg::*;
#(
    parameter int DW   = 64,
    parameter int NREG = 16,
    parameter int IW   = 4,
    parameter int NHB  = 4
) (
    input  logic [IW-1:0]             idx_i,
    input  logic [SELW-1:0]           sel_i,
    input  logic [NREG-1:0][DW-1:0]   regs_i,
    input  logic                      fwd_en_i,
    input  logic [IW-1:0]             fwd_idx_i,
    input  logic [DW-1:0]             fwd_val_i,
    output logic [DW-1:0]             data_o
);

    localparam int HALF = DW / 2;
    localparam logic [IW:0] NHB_W = (IW+1)'(NHB);

    logic [DW-1:0] src;
    logic          hb_ok;

    assign hb_ok = ({1'b0, idx_i} < NHB_W);
    assign src   = (fwd_en_i && (fwd_idx_i == idx_i)) ? fwd_val_i : regs_i[idx_i];

    always_comb begin
        unique case (sel_i)
            VW_FULL: data_o = src;
            VW_LO32: data_o = {{HALF{1'b0}}, src[HALF-1:0]};
            VW_LO16: data_o = {{(DW-16){1'b0}}, src[15:0]};
            VW_LO8:  data_o = {{(DW-8){1'b0}}, src[7:0]};
            VW_B1:   data_o = hb_ok ? {{(DW-8){1'b0}}, src[15:8]} : '0;
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
    import prf_pkg::*;
#(
    parameter int DW   = 64,
    parameter int NREG = 16,
    parameter int NHB  = 4,
    parameter int NRP  = 2,
    localparam int IW  = $clog2(NREG)
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       wr_en_i,
    input  logic [IW-1:0]              wr_idx_i,
    input  logic [SELW-1:0]            wr_sel_i,
    input  logic [DW-1:0]              wr_data_i,
    input  logic [NRP-1:0][IW-1:0]     rd_idx_i,
    input  logic [NRP-1:0][SELW-1:0]   rd_sel_i,
    output logic [NRP-1:0][DW-1:0]     rd_data_o,
    output logic                       wr_err_o
);

    logic [NREG-1:0][DW-1:0] regs;
    logic [DW-1:0]           merged;
    logic                    commit;
    logic                    bad;
    logic                    err_q;

    prf_wmerge #(.DW(DW), .IW(IW), .NHB(NHB)) u_wmerge (
        .en_i     (wr_en_i),
        .idx_i    (wr_idx_i),
        .sel_i    (wr_sel_i),
        .data_i   (wr_data_i),
        .old_i    (regs[wr_idx_i]),
        .new_o    (merged),
        .commit_o (commit),
        .bad_o    (bad)
    );

    prf_store #(.DW(DW), .NREG(NREG), .IW(IW)) u_store (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .we_i   (commit),
        .widx_i (wr_idx_i),
        .wval_i (merged),
        .regs_o (regs)
    );

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        prf_rview #(.DW(DW), .NREG(NREG), .IW(IW), .NHB(NHB)) u_rview (
            .idx_i     (rd_idx_i[p]),
            .sel_i     (rd_sel_i[p]),
            .regs_i    (regs),
            .fwd_en_i  (commit),
            .fwd_idx_i (wr_idx_i),
            .fwd_val_i (merged),
            .data_o    (rd_data_o[p])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad;
        end
    end

    assign wr_err_o = err_q;

endmodule

// File: rtl/prf_regfile_chk.sv
module prf_regfile_chk #(
    parameter int DW   = 64,
    parameter int NREG = 16,
    parameter int NHB  = 4,
    parameter int NRP  = 2,
    localparam int IW  = $clog2(NREG)
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     wr_en_i,
    input logic [IW-1:0]            wr_idx_i,
    input logic [2:0]               wr_sel_i,
    input logic [DW-1:0]            wr_data_i,
    input logic [NRP-1:0][IW-1:0]   rd_idx_i,
    input logic [NRP-1:0][2:0]      rd_sel_i,
    input logic [NRP-1:0][DW-1:0]   rd_data_o,
    input logic                     wr_err_o
);

    localparam int HALF = DW / 2;
    localparam logic [IW:0] NHB_W = (IW+1)'(NHB);

    logic hb_drop;
    assign hb_drop = wr_en_i && (wr_sel_i == 3'd4) && ({1'b0, wr_idx_i} >= NHB_W);

    assert_hb_err_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        hb_drop |=> wr_err_o);

    assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !hb_drop |=> !wr_err_o);

    assert_reset_err_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !wr_err_o);

    for (genvar p = 0; p < NRP; p++) begin : g_port
        assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(rst_i) && !wr_en_i) |-> (rd_data_o[p] == '0));

        assert_full_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(wr_en_i && wr_sel_i == 3'd0) && !wr_en_i
             && rd_idx_i[p] == $past(wr_idx_i) && rd_sel_i[p] == 3'd0)
            |-> (rd_data_o[p] == $past(wr_data_i)));

        assert_lo32_zext_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            ($past(wr_en_i && wr_sel_i == 3'd1) && !wr_en_i
             && rd_idx_i[p] == $past(wr_idx_i) && rd_sel_i[p] == 3'd0)
            |-> (rd_data_o[p] == {{HALF{1'b0}}, $past(wr_data_i[HALF-1:0])}));

        assert_bad_view_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            (rd_sel_i[p] > 3'd4) |-> (rd_data_o[p] == '0));

        assert_forward_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            (wr_en_i && wr_sel_i == 3'd0 && rd_idx_i[p] == wr_idx_i && rd_sel_i[p] == 3'd0)
            |-> (rd_data_o[p] == wr_data_i));
    end

endmodule

bind prf_regfile prf_regfile_chk #(.DW(DW), .NREG(NREG), .NHB(NHB), .NRP(NRP)) u_chk (.*);

// File: tb/test_prf_regfile.sv
module test_prf_regfile;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [3:0]       wr_idx;
    logic [2:0]       wr_sel;
    logic [63:0]      wr_data;
    logic [1:0][3:0]  rd_idx;
    logic [1:0][2:0]  rd_sel;
    logic [1:0][63:0] rd_data;
    logic             wr_err;

    logic [63:0] model [16];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prf_regfile i_prf_regfile (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .wr_err_o  (wr_err)
    );

    function automatic logic [63:0] f_merge(input logic [63:0] o, input logic [2:0] s,
                                            input logic [63:0] d);
        case (s)
            3'd0:    return d;
            3'd1:    return {32'h0, d[31:0]};
            3'd2:    return {o[63:16], d[15:0]};
            3'd3:    return {o[63:8], d[7:0]};
            3'd4:    return {o[63:16], d[7:0], o[7:0]};
            default: return o;
        endcase
    endfunction

    function automatic bit f_commit(input logic [2:0] s, input logic [3:0] i);
        return (s <= 3'd3) || (s == 3'd4 && i < 4'd4);
    endfunction

    function automatic logic [63:0] f_view(input logic [63:0] v, input logic [3:0] i,
                                           input logic [2:0] s);
        case (s)
            3'd0:    return v;
            3'd1:    return {32'h0, v[31:0]};
            3'd2:    return {48'h0, v[15:0]};
            3'd3:    return {56'h0, v[7:0]};
            3'd4:    return (i < 4'd4) ? {56'h0, v[15:8]} : 64'h0;
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [3:0] wi, input logic [2:0] ws,
                         input logic [63:0] wd, input logic [3:0] ri0, input logic [2:0] rs0,
                         input logic [3:0] ri1, input logic [2:0] rs1);
        wr_en = we; wr_idx = wi; wr_sel = ws; wr_data = wd;
        rd_idx[0] = ri0; rd_sel[0] = rs0; rd_idx[1] = ri1; rd_sel[1] = rs1;
    endtask

    // called right after a falling edge with inputs already driven
    task automatic run_cycle(input string tag);
        logic [63:0] src;
        bit com;
        bit ill;
        #1;
        com = wr_en && f_commit(wr_sel, wr_idx);
        ill = wr_en && wr_sel == 3'd4 && wr_idx >= 4'd4;
        for (int p = 0; p < 2; p++) begin
            src = (com && wr_idx == rd_idx[p]) ? f_merge(model[wr_idx], wr_sel, wr_data)
                                               : model[rd_idx[p]];
            check(tag, rd_data[p], f_view(src, rd_idx[p], rd_sel[p]));
        end
        @(posedge clk);
        #1;
        if (com) model[wr_idx] = f_merge(model[wr_idx], wr_sel, wr_data);
        check({tag, " / R7 error flag"}, {63'h0, wr_err}, {63'h0, ill});
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) model[i] = 64'h0;
        rst = 1'b1;
        drive(1'b1, 4'd3, 3'd0, 64'hDEAD_BEEF_0000_1111, 4'd0, 3'd0, 4'd1, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything zero after reset (inputs written during reset must not stick)
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 4'd0, 3'd0, 64'h0, 4'(i), 3'd0, 4'(15 - i), 3'd0);
            run_cycle("R1 reset clears");
        end

        // R2 + R10 + R11
        drive(1'b1, 4'd0, 3'd0, 64'h1122_3344_5566_7788, 4'd0, 3'd0, 4'd1, 3'd0);
        run_cycle("R10 forward full / R11 neighbour");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd0, 3'd0, 4'd0, 3'd1);
        run_cycle("R2 full write");

        // R3 nonzero data, then zero data
        drive(1'b1, 4'd0, 3'd1, 64'hFFFF_FFFF_5555_6666, 4'd0, 3'd0, 4'd0, 3'd1);
        run_cycle("R3 lo32 forward");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd0, 3'd0, 4'd0, 3'd2);
        run_cycle("R3 lo32 zero-extend");
        drive(1'b1, 4'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1, 3'd0, 4'd2, 3'd0);
        run_cycle("R2 all ones");
        drive(1'b1, 4'd0, 3'd1, 64'h0, 4'd1, 3'd0, 4'd2, 3'd0);
        run_cycle("R3 zero data");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd0, 3'd0, 4'd0, 3'd4);
        run_cycle("R3 upper cleared");

        // R4 / R5 / R6 on register 1
        drive(1'b1, 4'd1, 3'd0, 64'h1122_3344_5566_7788, 4'd2, 3'd0, 4'd3, 3'd0);
        run_cycle("R2 setup");
        drive(1'b1, 4'd1, 3'd2, 64'hAAAA_AAAA_AAAA_7777, 4'd1, 3'd0, 4'd0, 3'd0);
        run_cycle("R4 lo16 forward");
        drive(1'b1, 4'd1, 3'd3, 64'hFFFF_FFFF_FFFF_FFAB, 4'd2, 3'd0, 4'd1, 3'd2);
        run_cycle("R5 lo8 write");
        drive(1'b1, 4'd1, 3'd4, 64'hFFFF_FFFF_FFFF_FFCD, 4'd2, 3'd0, 4'd2, 3'd1);
        run_cycle("R6 byte1 write");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd1, 3'd0, 4'd1, 3'd4);
        run_cycle("R4 R5 R6 merged value");

        // R7: byte1 write to register 5 is dropped and not forwarded
        drive(1'b1, 4'd5, 3'd0, 64'h0102_0304_0506_0708, 4'd0, 3'd0, 4'd1, 3'd0);
        run_cycle("R2 setup reg5");
        drive(1'b1, 4'd5, 3'd4, 64'h0000_0000_0000_00EE, 4'd5, 3'd0, 4'd5, 3'd3);
        run_cycle("R7 R10 dropped write not forwarded");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd5, 3'd0, 4'd5, 3'd2);
        run_cycle("R7 reg5 unchanged, flag clears");

        // R8: unused write codes
        for (int c = 5; c < 8; c++) begin
            drive(1'b1, 4'd1, 3'(c), 64'h9999_9999_9999_9999, 4'd1, 3'd0, 4'd1, 3'd1);
            run_cycle("R8 unused write code");
        end
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd1, 3'd0, 4'd0, 3'd0);
        run_cycle("R8 register intact");

        // R9: unused read codes and byte1 view on high registers
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd1, 3'd5, 4'd5, 3'd4);
        run_cycle("R9 zero views");
        drive(1'b0, 4'd0, 3'd0, 64'h0, 4'd1, 3'd7, 4'd1, 3'd6);
        run_cycle("R9 zero views 2");

        // Random traffic, indices biased to collide
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] wi;
            wi = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom % 16);
            drive(($urandom % 4) != 0, wi, 3'($urandom % 8), {$urandom, $urandom},
                  ($urandom % 3 == 0) ? wi : 4'($urandom % 16), 3'($urandom % 8),
                  ($urandom % 3 == 0) ? wi : 4'($urandom % 16), 3'($urandom % 8));
            run_cycle("R9 R10 R11 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule